// File: doc/BRIEF.md
# Ultra DMA Burst CRC Unit

This block keeps the 16-bit check value of an Ultra DMA transfer. During a burst, every data word accepted on a strobe edge is folded into a running CRC register. The register is loaded with a fixed seed whenever a burst starts. Each word-wide update gives the same result as sixteen single-bit shifts. Bit 0 of the word enters first and bit 15 last. The generator polynomial is x^16 + x^12 + x^5 + 1.

When the unit sends data, the running value on `crc_o` is the word to drive onto the data bus while the burst terminates. When the unit receives data, a capture strobe marks the release of the DMA acknowledge. On that strobe the unit takes the sender's CRC from the data bus and compares it with its own value. A per-burst miscompare flag shows the result of that comparison. A sticky flag, together with the 1-based number of the failing burst, keeps the first failure seen since the last command-start pulse. Later failures within the same command do not overwrite it.

Top module: `udma_crc_unit`

## Requirements
- R1: Each accepted word updates the CRC (polynomial 0x1021) exactly as sixteen serial shifts would. In each shift the feedback bit is crc[15] XOR word_i[k], taken for k = 0 first up to k = 15 last.
- R2: A `burst_start_i` pulse loads 0x4ABA into the CRC in the next cycle and opens a burst. It also does this during an open burst, and it outranks a strobed word or a capture in the same cycle. The CRC also reads 0x4ABA after reset.
- R3: A `word_valid_i` strobe while no burst is open leaves `crc_o` unchanged.
- R4: `crc_o` shows the updated value one cycle after each accepted word, so the sending side can drive it at burst end.
- R5: `crc_capture_i` during an open burst closes the burst and compares `word_i` with the current CRC. One cycle later, `miscompare_o` is 1 exactly when the two differ. A word strobed in the capture cycle is not folded.
- R6: `first_err_o` sets on the first miscompare of a command. It then stays set across later bursts, and `burst_start_i` does not clear it.
- R7: `err_burst_o` holds the 1-based number of the burst that first failed within the command. Later failures leave it unchanged. The burst count saturates at 15.
- R8: `cmd_start_i` clears `first_err_o`, `err_burst_o`, `miscompare_o` and the burst count in the next cycle. It outranks a capture in the same cycle.
- R9: A capture strobe while no burst is open changes no output.
- R10: `miscompare_o` clears on `burst_start_i` and holds its value between captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_start_i | input | 1 | Start of a new command; clears the error record |
| burst_start_i | input | 1 | Start of a burst; seeds the CRC |
| word_valid_i | input | 1 | A data word is present on `word_i` |
| word_i | input | 16 | Data word, or the sender's CRC at capture |
| crc_capture_i | input | 1 | End of burst; compare `word_i` with the CRC |
| crc_o | output | 16 | Running CRC |
| miscompare_o | output | 1 | Last capture of this burst mismatched |
| first_err_o | output | 1 | Sticky first-error flag for the command |
| err_burst_o | output | 4 | Number of the first failing burst |

## Verification
The assertions check the following on every cycle: the seed load after a burst start, the CRC holding while no burst is open, the sticky flag and its burst number staying put until a command start, the clear after a command start, and a miscompare rising only after a capture in an open burst. Only the bench's scenarios can show that the parallel update matches a bit-serial model. The same holds for detection of a corrupted CRC word, and for the first failing burst winning over later ones in a multi-burst command. These scenarios run over random word streams with idle strobes in between.

// File: rtl/udma_crc_pkg.sv
package udma_crc_pkg;
  localparam int unsigned CRC_W  = 16;
  localparam int unsigned BCNT_W = 4;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [CRC_W-1:0] CRC_SEED = 16'h4ABA;

  typedef logic [CRC_W-1:0]  crc_t;
  typedef logic [BCNT_W-1:0] bcnt_t;
endpackage

// File: rtl/crc_word_engine.sv
module crc_word_engine
  import udma_crc_pkg::*;
#(
  parameter crc_t POLY = CRC_POLY,
  parameter crc_t SEED = CRC_SEED
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic seed_i,
  input  logic fold_i,
  input  crc_t word_i,
  output crc_t crc_o
);
  crc_t crc_q;
  crc_t chain [CRC_W+1];

  assign chain[0] = crc_q;

  // one serial shift per stage, bit 0 of the word first
  for (genvar g = 0; g < CRC_W; g++) begin : g_stage
    logic fb;
    assign fb = chain[g][CRC_W-1] ^ word_i[g];
    assign chain[g+1] = {chain[g][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= SEED;
    else if (seed_i) crc_q <= SEED;
    else if (fold_i) crc_q <= chain[CRC_W];
  end

  assign crc_o = crc_q;

  a_r2_seed_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_i |=> crc_q == SEED);
  a_r3_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!seed_i && !fold_i) |=> crc_q == $past(crc_q));
endmodule

// File: rtl/udma_burst_ctl.sv
module udma_burst_ctl
  import udma_crc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  cmd_start_i,
  input  logic  burst_start_i,
  input  logic  word_valid_i,
  input  logic  crc_capture_i,
  output logic  seed_o,
  output logic  fold_o,
  output logic  capture_o,
  output bcnt_t burst_cnt_o
);
  localparam bcnt_t CNT_MAX = '1;

  logic  active_q;
  bcnt_t cnt_q, cnt_base;

  assign seed_o    = burst_start_i;
  assign capture_o = crc_capture_i & active_q & ~burst_start_i;
  assign fold_o    = word_valid_i & active_q & ~burst_start_i & ~crc_capture_i;
  assign cnt_base  = cmd_start_i ? '0 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      if (burst_start_i)      active_q <= 1'b1;
      else if (crc_capture_i) active_q <= 1'b0;
      if (burst_start_i && cnt_base != CNT_MAX) cnt_q <= cnt_base + 1'b1;
      else                                      cnt_q <= cnt_base;
    end
  end

  assign burst_cnt_o = cnt_q;

  a_r5_capture_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_o |=> !active_q);
  a_r7_cnt_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !cmd_start_i) |=> cnt_q == CNT_MAX);
endmodule

// File: rtl/crc_check.sv
module crc_check
  import udma_crc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  cmd_start_i,
  input  logic  burst_start_i,
  input  logic  capture_i,
  input  crc_t  rx_crc_i,
  input  crc_t  calc_crc_i,
  input  bcnt_t burst_cnt_i,
  output logic  miscompare_o,
  output logic  first_err_o,
  output bcnt_t err_burst_o
);
  logic  mis_q, err_q, mismatch;
  bcnt_t idx_q;

  assign mismatch = rx_crc_i != calc_crc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mis_q <= 1'b0;
      err_q <= 1'b0;
      idx_q <= '0;
    end else begin
      if (cmd_start_i || burst_start_i) mis_q <= 1'b0;
      else if (capture_i)               mis_q <= mismatch;
      if (cmd_start_i) begin
        err_q <= 1'b0;
        idx_q <= '0;
      end else if (capture_i && mismatch && !err_q) begin
        err_q <= 1'b1;
        idx_q <= burst_cnt_i;
      end
    end
  end

  assign miscompare_o = mis_q;
  assign first_err_o  = err_q;
  assign err_burst_o  = idx_q;

  a_r6_sticky_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !cmd_start_i) |=> err_q);
  a_r7_first_idx_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !cmd_start_i) |=> $stable(idx_q));
  a_r8_cmd_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_start_i |=> (!err_q && !mis_q && idx_q == '0));
  a_r5_mis_from_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mis_q && !capture_i) |=> !mis_q);
endmodule

// File: rtl/udma_crc_unit.sv
module udma_crc_unit
  import udma_crc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_start_i,
  input  logic        burst_start_i,
  input  logic        word_valid_i,
  input  logic [15:0] word_i,
  input  logic        crc_capture_i,
  output logic [15:0] crc_o,
  output logic        miscompare_o,
  output logic        first_err_o,
  output logic [3:0]  err_burst_o
);
  logic  seed, fold, capture;
  bcnt_t burst_cnt;
  crc_t  crc;

  udma_burst_ctl u_ctl (
    .clk_i, .rst_ni, .cmd_start_i, .burst_start_i, .word_valid_i, .crc_capture_i,
    .seed_o(seed), .fold_o(fold), .capture_o(capture), .burst_cnt_o(burst_cnt)
  );

  crc_word_engine #(.POLY(CRC_POLY), .SEED(CRC_SEED)) u_engine (
    .clk_i, .rst_ni, .seed_i(seed), .fold_i(fold), .word_i(word_i), .crc_o(crc)
  );

  crc_check u_check (
    .clk_i, .rst_ni, .cmd_start_i, .burst_start_i, .capture_i(capture),
    .rx_crc_i(word_i), .calc_crc_i(crc), .burst_cnt_i(burst_cnt),
    .miscompare_o, .first_err_o, .err_burst_o
  );

  assign crc_o = crc;
endmodule

// File: tb/udma_crc_unit_bench.sv
module udma_crc_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_start_i = 1'b0, burst_start_i = 1'b0, word_valid_i = 1'b0, crc_capture_i = 1'b0;
  logic [15:0] word_i = '0;
  logic [15:0] crc_o;
  logic        miscompare_o, first_err_o;
  logic [3:0]  err_burst_o;

  int total = 0, bad = 0;
  bit done = 0;

  logic [15:0] m_crc = 16'h4ABA;
  logic        m_act = 0, m_mis = 0, m_err = 0;
  logic [3:0]  m_cnt = 0, m_idx = 0;

  always #2.5 clk_i = ~clk_i;

  udma_crc_unit u_udma_crc_unit (.*);

  // bit-serial reference: one LFSR step per data bit, bit 0 first
  function automatic logic [15:0] ser_crc(logic [15:0] c, logic [15:0] w);
    for (int i = 0; i < 16; i++) begin
      logic fb;
      fb = c[15] ^ w[i];
      c  = {c[14:12], c[11] ^ fb, c[10:5], c[4] ^ fb, c[3:0], fb};
    end
    return c;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " R1 R4 crc"}, crc_o, m_crc);
    chk({tag, " R5 R10 miscompare"}, {15'd0, miscompare_o}, {15'd0, m_mis});
    chk({tag, " R6 first_err"}, {15'd0, first_err_o}, {15'd0, m_err});
    chk({tag, " R7 err_burst"}, {12'd0, err_burst_o}, {12'd0, m_idx});
  endtask

  task automatic cyc(logic cs, logic bs, logic v, logic cap, logic [15:0] w, string tag);
    logic cap_ev, fold, mism;
    cmd_start_i = cs; burst_start_i = bs; word_valid_i = v; crc_capture_i = cap; word_i = w;
    @(posedge clk_i); #1;
    cap_ev = cap && m_act && !bs;
    fold   = v && m_act && !bs && !cap;
    mism   = (w != m_crc);
    if (cs) begin m_err = 0; m_idx = 0; end
    else if (cap_ev && mism && !m_err) begin m_err = 1; m_idx = m_cnt; end
    m_mis = (cs || bs) ? 1'b0 : (cap_ev ? mism : m_mis);
    begin
      logic [3:0] base;
      base  = cs ? 4'd0 : m_cnt;
      m_cnt = (bs && base != 4'hF) ? base + 4'd1 : base;
    end
    m_crc = bs ? 16'h4ABA : (fold ? ser_crc(m_crc, w) : m_crc);
    m_act = bs ? 1'b1 : (cap ? 1'b0 : m_act);
    cmd_start_i = 0; burst_start_i = 0; word_valid_i = 0; crc_capture_i = 0;
    check_all(tag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    #12; @(negedge clk_i);
    check_all("reset R2");
    rst_ni = 1;
    @(posedge clk_i); #1;

    // R3/R9: strobes and capture before any burst
    cyc(1, 0, 0, 0, 0, "cmd R8");
    cyc(0, 0, 1, 0, 16'h1234, "idle word R3");
    cyc(0, 0, 0, 1, 16'h0000, "idle capture R9");

    // R2: empty burst, correct seed returned
    cyc(0, 1, 0, 0, 0, "seed R2");
    cyc(0, 0, 0, 1, 16'h4ABA, "empty burst R2");

    // R1 directed: single word 0x0001 against serial model
    cyc(0, 1, 0, 0, 0, "seed R2");
    cyc(0, 0, 1, 0, 16'h0001, "one word R1");
    cyc(0, 0, 1, 1, 16'hFFFF, "word in capture cycle R5");
    cyc(0, 0, 1, 0, 16'h5555, "post-capture word R3");
    // R6/R10: burst start clears miscompare, keeps sticky
    cyc(0, 1, 0, 0, 0, "restart R10 R6");
    cyc(0, 0, 0, 1, 16'h0000, "second fail keeps idx R7");
    cyc(1, 0, 0, 1, 16'h4ABA, "cmd beats capture R8");

    // random commands
    for (int c = 0; c < 40; c++) begin
      int nb;
      cyc(1, 0, 0, 0, 0, "cmd R8");
      nb = 1 + $urandom_range(0, 5);
      if (c == 0) nb = 18; // saturate burst count R7
      for (int b = 0; b < nb; b++) begin
        int nw;
        logic [15:0] tx;
        cyc(0, 1, $urandom_range(0, 1), 0, 16'($urandom), "burst R2");
        nw = $urandom_range(0, 24);
        for (int k = 0; k < nw; k++) begin
          if ($urandom_range(0, 3) == 0) cyc(0, 0, 0, 0, 16'($urandom), "gap R3");
          cyc(0, 0, 1, 0, 16'($urandom), "word R1");
        end
        tx = m_crc;
        if ($urandom_range(0, 3) == 0) tx = tx ^ (16'h1 << $urandom_range(0, 15));
        cyc(0, 0, $urandom_range(0, 1), 1, tx, "capture R5");
        cyc(0, 0, 1, 0, 16'($urandom), "idle word R3");
        if ($urandom_range(0, 4) == 0) cyc(0, 0, 0, 1, 16'($urandom), "idle capture R9");
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule